// File: doc/BRIEF.md
# Two-Register Compact Branch Resolver

This block takes a decoded 32-bit instruction word from one of two major opcode groups, together with its program counter, the two source register indices and the values read for them. It works out what the branch does. Each group uses a 2-bit selector at bits 15:14 to pick the comparison. The relation between the two register indices can change the meaning of an encoding. A first index of zero turns the compare into a test of the second register against zero. Equal indices give an unconditional branch, a zero test or a no-operation, depending on the selector. One selector value opens a floating-point subgroup that branches on a supplied condition bit.

The result is registered and appears one cycle after the request. It is the next program counter, a taken flag, a no-operation flag, two exception flags and an optional request to write PC+4 into the return register r31. The parameter `ZERO_LINK` picks how the unsigned selectors treat their index special cases. With 0, they follow the shortcut forms: unconditional, equal-to-zero or no-operation. With 1, they become linking zero compares.

Top module: `cbr_resolve`

## Requirements
- R1: The branch offset is formed from bit 0 as the sign at weight -16384 plus bits 13:1 times two. A taken branch gives next_pc = pc + 4 + offset. A not-taken branch or a no-operation gives next_pc = pc + 4.
- R2: Selector 0 compares the two register values: group A branches when they are equal, group B when they differ. The indices have no effect.
- R3: Group A selector 2 branches unconditionally when rs_idx equals rt_idx. With rs_idx 0 and rt_idx nonzero, it branches when rt_val is at most zero (signed). Otherwise it branches when rs_val is at least rt_val (signed).
- R4: Group B selector 2 is a no-operation when the indices are equal and nonzero. With rs_idx 0 and rt_idx nonzero, it branches when rt_val is above zero (signed). Otherwise it branches when rs_val is below rt_val (signed).
- R5: With ZERO_LINK=0, group A selector 3 branches unconditionally when the indices are equal or rt_idx is 0. Otherwise, with rs_idx 0, it branches when rt_val is zero. In all other cases it branches when rs_val is at least rt_val (unsigned).
- R6: With ZERO_LINK=0, group B selector 3 is a no-operation when rs_idx is 0 or the indices are equal. Otherwise it branches when rs_val is below rt_val (unsigned).
- R7: With ZERO_LINK=1, the selector 3 forms change as follows, each raising link_req with link_addr = pc + 4 whether or not the branch is taken.
  - Group A, rs_idx 0 and rt_idx nonzero: tests rt_val at most zero.
  - Group A, equal nonzero indices: tests rt_val at least zero.
  - Group B, rs_idx 0 and rt_idx nonzero: tests rt_val above zero.
  - Group B, equal nonzero indices: tests rt_val below zero.
  - Group B, both indices zero: a no-operation.
  - Group A with rt_idx 0: still unconditional.
  - All other selector 3 forms: compare unsigned as in R5 and R6.
- R8: Group A selector 1 is the floating-point subgroup, with the code in bits 20:16. With fpu_en low it raises cop_exc. Code 8 branches when fp_bit is 0, code 9 when fp_bit is 1.
- R9: These raise ri_exc: group B selector 1, any floating-point subgroup code other than 8 or 9 while fpu_en is high, and any major opcode (bits 31:26) other than 0x22 (group A) or 0x2A (group B). An exception gives next_pc = pc, with taken, link_req and is_nop low.
- R10: A no-operation raises is_nop with taken, link_req, ri_exc and cop_exc low.
- R11: Each request with valid_in high yields out_valid and its result exactly one clock later. Reset clears out_valid and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Request strobe |
| instr | input | 32 | Instruction word |
| pc | input | XLEN | Address of the instruction |
| rs_idx | input | 5 | First source register index |
| rt_idx | input | 5 | Second source register index |
| rs_val | input | XLEN | Value of the first source register |
| rt_val | input | XLEN | Value of the second source register |
| fp_bit | input | 1 | Bit 0 of the selected floating-point register |
| fpu_en | input | 1 | Floating-point unit enabled |
| out_valid | output | 1 | Result strobe |
| taken | output | 1 | Branch taken |
| next_pc | output | XLEN | Next program counter |
| link_req | output | 1 | Request to write link_addr into r31 |
| link_addr | output | XLEN | Return address (pc + 4) |
| is_nop | output | 1 | Encoding resolved as no-operation |
| ri_exc | output | 1 | Reserved-instruction exception |
| cop_exc | output | 1 | Floating-point unit disabled exception |

## Verification
Every selector is driven with index pairs from each class: distinct nonzero indices, rs_idx zero, rt_idx zero, equal nonzero and both zero. This shows that the index relation, and not the values, picks the operation. Register values are chosen so that signed and unsigned orderings disagree, for example all-ones against one. A wrong choice of compare then shows in the taken flag. The same stimulus feeds a second instance built with ZERO_LINK=1. Values such as rt_val = -1 with rs_idx 0 under selector 3 separate the zero-equal test from the at-most-zero test, and separate the shortcut forms from the linking forms. Offsets with the sign bit set and clear check the target arithmetic, and bad codes, opcodes and a disabled unit cover the exception paths.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    typedef enum logic [4:0] {
        OP_UNCOND,
        OP_EQ,
        OP_NE,
        OP_GE_S,
        OP_LT_S,
        OP_GE_U,
        OP_LT_U,
        OP_ZEQ,
        OP_ZLE,
        OP_ZGT,
        OP_ZGE,
        OP_ZLT,
        OP_FP_CLR,
        OP_FP_SET,
        OP_NOP,
        OP_RSVD,
        OP_COPOFF
    } cbr_op_e;

    typedef struct packed {
        cbr_op_e op;
        logic    link;
    } cbr_dec_t;

    // selector positions shared by both groups
    localparam logic [1:0] SEL_CMP0 = 2'd0;
    localparam logic [1:0] SEL_ALT  = 2'd1;
    localparam logic [1:0] SEL_SGN  = 2'd2;
    localparam logic [1:0] SEL_USG  = 2'd3;

    localparam int OFF_W = 15;

    function automatic logic [5:0] major_of(input logic [31:0] w);
        return w[31:26];
    endfunction

    function automatic logic [1:0] sel_of(input logic [31:0] w);
        return w[15:14];
    endfunction

    function automatic logic [4:0] sub_of(input logic [31:0] w);
        return w[20:16];
    endfunction

    function automatic logic [OFF_W-1:0] off_of(input logic [31:0] w);
        return {w[0], w[13:1], 1'b0};
    endfunction

endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
    import cbr_pkg::*;
#(
    parameter logic [5:0] MAJ_A       = 6'h22,
    parameter logic [5:0] MAJ_B       = 6'h2a,
    parameter logic [4:0] FP_CLR_CODE = 5'd8,
    parameter logic [4:0] FP_SET_CODE = 5'd9,
    parameter bit         ZERO_LINK   = 1'b0
) (
    input  logic [31:0] instr,
    input  logic [4:0]  rs_idx,
    input  logic [4:0]  rt_idx,
    input  logic        fpu_en,
    output cbr_dec_t    dec
);

    logic       rs_z, rt_z, same;
    logic [1:0] sel;
    logic [4:0] sub;
    logic [5:0] maj;
    logic       unused_bits;

    assign rs_z        = (rs_idx == 5'd0);
    assign rt_z        = (rt_idx == 5'd0);
    assign same        = (rs_idx == rt_idx);
    assign sel         = sel_of(instr);
    assign sub         = sub_of(instr);
    assign maj         = major_of(instr);
    assign unused_bits = ^instr[25:21];

    cbr_dec_t dec_a, dec_b;

    // group A: equal, FP subgroup, signed >=, unsigned >=
    always_comb begin
        dec_a = '{op: OP_RSVD, link: 1'b0};
        unique case (sel)
            SEL_CMP0: dec_a.op = OP_EQ;
            SEL_ALT: begin
                if (!fpu_en)                 dec_a.op = OP_COPOFF;
                else if (sub == FP_CLR_CODE) dec_a.op = OP_FP_CLR;
                else if (sub == FP_SET_CODE) dec_a.op = OP_FP_SET;
                else                         dec_a.op = OP_RSVD;
            end
            SEL_SGN: begin
                if (same)               dec_a.op = OP_UNCOND;
                else if (rs_z)          dec_a.op = OP_ZLE;
                else                    dec_a.op = OP_GE_S;
            end
            SEL_USG: begin
                if (ZERO_LINK) begin
                    if (rt_z)           dec_a.op = OP_UNCOND;
                    else if (rs_z)      dec_a = '{op: OP_ZLE, link: 1'b1};
                    else if (same)      dec_a = '{op: OP_ZGE, link: 1'b1};
                    else                dec_a.op = OP_GE_U;
                end else begin
                    if (same || rt_z)   dec_a.op = OP_UNCOND;
                    else if (rs_z)      dec_a.op = OP_ZEQ;
                    else                dec_a.op = OP_GE_U;
                end
            end
            default: dec_a.op = OP_RSVD;
        endcase
    end

    // group B: not-equal, hole, signed <, unsigned <
    always_comb begin
        dec_b = '{op: OP_RSVD, link: 1'b0};
        unique case (sel)
            SEL_CMP0: dec_b.op = OP_NE;
            SEL_ALT:  dec_b.op = OP_RSVD;
            SEL_SGN: begin
                if (same && !rs_z)      dec_b.op = OP_NOP;
                else if (rs_z && !rt_z) dec_b.op = OP_ZGT;
                else                    dec_b.op = OP_LT_S;
            end
            SEL_USG: begin
                if (ZERO_LINK) begin
                    if (rs_z && rt_z)   dec_b.op = OP_NOP;
                    else if (rs_z)      dec_b = '{op: OP_ZGT, link: 1'b1};
                    else if (same)      dec_b = '{op: OP_ZLT, link: 1'b1};
                    else                dec_b.op = OP_LT_U;
                end else begin
                    if (rs_z || same)   dec_b.op = OP_NOP;
                    else                dec_b.op = OP_LT_U;
                end
            end
            default: dec_b.op = OP_RSVD;
        endcase
    end

    always_comb begin
        if (maj == MAJ_A)      dec = dec_a;
        else if (maj == MAJ_B) dec = dec_b;
        else                   dec = '{op: OP_RSVD, link: 1'b0};
    end

endmodule

// File: rtl/cbr_eval.sv
module cbr_eval
    import cbr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cbr_op_e          op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    input  logic             fp_bit,
    output logic             take
);

    logic b_zero, b_neg;
    assign b_zero = (b == '0);
    assign b_neg  = b[XLEN-1];

    always_comb begin
        unique case (op)
            OP_UNCOND: take = 1'b1;
            OP_EQ:     take = (a == b);
            OP_NE:     take = (a != b);
            OP_GE_S:   take = ($signed(a) >= $signed(b));
            OP_LT_S:   take = ($signed(a) <  $signed(b));
            OP_GE_U:   take = (a >= b);
            OP_LT_U:   take = (a <  b);
            OP_ZEQ:    take = b_zero;
            OP_ZLE:    take = b_zero || b_neg;
            OP_ZGT:    take = !b_zero && !b_neg;
            OP_ZGE:    take = !b_neg;
            OP_ZLT:    take = b_neg;
            OP_FP_CLR: take = !fp_bit;
            OP_FP_SET: take = fp_bit;
            default:   take = 1'b0;
        endcase
    end

endmodule

// File: rtl/cbr_target.sv
module cbr_target
    import cbr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic [31:0]     instr,
    output logic [XLEN-1:0] seq_pc,
    output logic [XLEN-1:0] br_pc
);

    localparam int EXT_W = XLEN - OFF_W;

    logic [OFF_W-1:0] off;
    logic [XLEN-1:0]  off_x;

    assign off    = off_of(instr);
    assign off_x  = {{EXT_W{off[OFF_W-1]}}, off};
    assign seq_pc = pc + XLEN'(4);
    assign br_pc  = seq_pc + off_x;

endmodule

// File: rtl/cbr_resolve.sv
module cbr_resolve
    import cbr_pkg::*;
#(
    parameter int         XLEN        = 32,
    parameter logic [5:0] MAJ_A       = 6'h22,
    parameter logic [5:0] MAJ_B       = 6'h2a,
    parameter logic [4:0] FP_CLR_CODE = 5'd8,
    parameter logic [4:0] FP_SET_CODE = 5'd9,
    parameter bit         ZERO_LINK   = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid_in,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] pc,
    input  logic [4:0]      rs_idx,
    input  logic [4:0]      rt_idx,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    input  logic            fp_bit,
    input  logic            fpu_en,
    output logic            out_valid,
    output logic            taken,
    output logic [XLEN-1:0] next_pc,
    output logic            link_req,
    output logic [XLEN-1:0] link_addr,
    output logic            is_nop,
    output logic            ri_exc,
    output logic            cop_exc
);

    cbr_dec_t        dec;
    logic            take_c;
    logic [XLEN-1:0] seq_pc, br_pc;

    cbr_decode #(
        .MAJ_A(MAJ_A), .MAJ_B(MAJ_B),
        .FP_CLR_CODE(FP_CLR_CODE), .FP_SET_CODE(FP_SET_CODE),
        .ZERO_LINK(ZERO_LINK)
    ) u_dec (
        .instr(instr), .rs_idx(rs_idx), .rt_idx(rt_idx),
        .fpu_en(fpu_en), .dec(dec)
    );

    cbr_eval #(.XLEN(XLEN)) u_eval (
        .op(dec.op), .a(rs_val), .b(rt_val), .fp_bit(fp_bit), .take(take_c)
    );

    cbr_target #(.XLEN(XLEN)) u_tgt (
        .pc(pc), .instr(instr), .seq_pc(seq_pc), .br_pc(br_pc)
    );

    logic            exc_c, nop_c, ri_c, cop_c;
    logic [XLEN-1:0] nxt_c;

    assign ri_c  = (dec.op == OP_RSVD);
    assign cop_c = (dec.op == OP_COPOFF);
    assign nop_c = (dec.op == OP_NOP);
    assign exc_c = ri_c || cop_c;
    assign nxt_c = exc_c ? pc : (take_c ? br_pc : seq_pc);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            taken     <= 1'b0;
            next_pc   <= '0;
            link_req  <= 1'b0;
            link_addr <= '0;
            is_nop    <= 1'b0;
            ri_exc    <= 1'b0;
            cop_exc   <= 1'b0;
        end else begin
            out_valid <= valid_in;
            taken     <= valid_in && take_c;
            next_pc   <= nxt_c;
            link_req  <= valid_in && dec.link;
            link_addr <= seq_pc;
            is_nop    <= valid_in && nop_c;
            ri_exc    <= valid_in && ri_c;
            cop_exc   <= valid_in && cop_c;
        end
    end

    // R11
    lat_one_chk: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> out_valid);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(taken || link_req || is_nop || ri_exc || cop_exc));

    // R10
    outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({taken, is_nop, ri_exc, cop_exc}));

    // R7
    link_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && dec.link) |=> (link_req && link_addr == $past(pc) + XLEN'(4)));

    // R9
    exc_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && exc_c) |=> (next_pc == $past(pc) && !link_req));

    // R1
    nop_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && nop_c) |=> (next_pc == $past(pc) + XLEN'(4) && !taken));

endmodule

// File: tb/tb_cbr_resolve.sv
module tb_cbr_resolve;

    localparam int XLEN = 32;

    typedef struct {
        logic        tk;
        logic [31:0] nx;
        logic        lk;
        logic [31:0] la;
        logic        np;
        logic        ri;
        logic        cp;
    } res_t;

    typedef struct {
        res_t  m0;
        res_t  m1;
        string tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_in = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] pc = '0;
    logic [4:0]  rs_idx = '0, rt_idx = '0;
    logic [31:0] rs_val = '0, rt_val = '0;
    logic        fp_bit = 1'b0, fpu_en = 1'b1;

    logic        ov0, tk0, lk0, np0, ri0, cp0;
    logic [31:0] nx0, la0;
    logic        ov1, tk1, lk1, np1, ri1, cp1;
    logic [31:0] nx1, la1;

    int total = 0;
    int bad   = 0;
    item_t q[$];
    bit    done = 0;

    always #10 clk = ~clk;

    cbr_resolve #(.XLEN(XLEN), .ZERO_LINK(1'b0)) dut (
        .clk(clk), .rst(rst), .valid_in(valid_in), .instr(instr), .pc(pc),
        .rs_idx(rs_idx), .rt_idx(rt_idx), .rs_val(rs_val), .rt_val(rt_val),
        .fp_bit(fp_bit), .fpu_en(fpu_en),
        .out_valid(ov0), .taken(tk0), .next_pc(nx0), .link_req(lk0),
        .link_addr(la0), .is_nop(np0), .ri_exc(ri0), .cop_exc(cp0)
    );

    cbr_resolve #(.XLEN(XLEN), .ZERO_LINK(1'b1)) dut_lk (
        .clk(clk), .rst(rst), .valid_in(valid_in), .instr(instr), .pc(pc),
        .rs_idx(rs_idx), .rt_idx(rt_idx), .rs_val(rs_val), .rt_val(rt_val),
        .fp_bit(fp_bit), .fpu_en(fpu_en),
        .out_valid(ov1), .taken(tk1), .next_pc(nx1), .link_req(lk1),
        .link_addr(la1), .is_nop(np1), .ri_exc(ri1), .cop_exc(cp1)
    );

    function automatic res_t model(input bit zl, input logic [5:0] maj,
        input logic [1:0] sel, input logic [4:0] sub, input logic [4:0] rs,
        input logic [4:0] rt, input logic [31:0] a, input logic [31:0] b,
        input logic fp, input logic en, input logic [31:0] p,
        input logic [31:0] w);
        res_t r;
        int   off;
        int   sa, sb;
        bit   t;
        sa  = a;
        sb  = b;
        off = int'(w[13:1]) * 2 - (w[0] ? 16384 : 0);
        r   = '{tk: 0, nx: p + 4, lk: 0, la: p + 4, np: 0, ri: 0, cp: 0};
        t   = 0;
        if (maj == 6'h22) begin
            case (sel)
                2'd0: t = (a == b);
                2'd1: begin
                    if (!en) r.cp = 1;
                    else if (sub == 5'd8) t = (fp == 1'b0);
                    else if (sub == 5'd9) t = (fp == 1'b1);
                    else r.ri = 1;
                end
                2'd2: begin
                    if (rs == rt) t = 1;
                    else if (rs == 0) t = (sb <= 0);
                    else t = (sa >= sb);
                end
                default: begin
                    if (!zl) begin
                        if (rs == rt || rt == 0) t = 1;
                        else if (rs == 0) t = (b == 0);
                        else t = (a >= b);
                    end else begin
                        if (rt == 0) t = 1;
                        else if (rs == 0) begin t = (sb <= 0); r.lk = 1; end
                        else if (rs == rt) begin t = (sb >= 0); r.lk = 1; end
                        else t = (a >= b);
                    end
                end
            endcase
        end else if (maj == 6'h2a) begin
            case (sel)
                2'd0: t = (a != b);
                2'd1: r.ri = 1;
                2'd2: begin
                    if (rs == rt && rs != 0) r.np = 1;
                    else if (rs == 0 && rt != 0) t = (sb > 0);
                    else t = (sa < sb);
                end
                default: begin
                    if (!zl) begin
                        if (rs == 0 || rs == rt) r.np = 1;
                        else t = (a < b);
                    end else begin
                        if (rs == 0 && rt == 0) r.np = 1;
                        else if (rs == 0) begin t = (sb > 0); r.lk = 1; end
                        else if (rs == rt) begin t = (sb < 0); r.lk = 1; end
                        else t = (a < b);
                    end
                end
            endcase
        end else begin
            r.ri = 1;
        end
        if (r.ri || r.cp) r.nx = p;
        else if (t) begin r.tk = 1; r.nx = p + 4 + off; end
        return r;
    endfunction

    task automatic send(input string tag, input logic [5:0] maj,
        input logic [1:0] sel, input logic [4:0] sub, input logic [4:0] rs,
        input logic [4:0] rt, input logic [31:0] a, input logic [31:0] b,
        input logic fp, input logic en, input logic [31:0] p,
        input logic [13:0] offbits);
        item_t it;
        logic [31:0] w;
        w = {maj, 5'd0, sub, sel, offbits};
        it.m0  = model(1'b0, maj, sel, sub, rs, rt, a, b, fp, en, p, w);
        it.m1  = model(1'b1, maj, sel, sub, rs, rt, a, b, fp, en, p, w);
        it.tag = tag;
        @(negedge clk);
        q.push_back(it);
        valid_in = 1'b1; instr = w; pc = p; rs_idx = rs; rt_idx = rt;
        rs_val = a; rt_val = b; fp_bit = fp; fpu_en = en;
    endtask

    task automatic idle();
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    task automatic cmp(input string tag, input string who, input res_t e,
        input logic tk, input logic [31:0] nx, input logic lk,
        input logic [31:0] la, input logic np, input logic ri, input logic cp);
        total++;
        if (tk !== e.tk || nx !== e.nx || lk !== e.lk || (e.lk && la !== e.la) ||
            np !== e.np || ri !== e.ri || cp !== e.cp) begin
            bad++;
            $display("FAIL %s %s: got tk=%0b nx=%h lk=%0b la=%h np=%0b ri=%0b cp=%0b exp tk=%0b nx=%h lk=%0b la=%h np=%0b ri=%0b cp=%0b",
                tag, who, tk, nx, lk, la, np, ri, cp,
                e.tk, e.nx, e.lk, e.la, e.np, e.ri, e.cp);
        end
    endtask

    // monitor: compares each result against the queued expectation
    always @(negedge clk) begin
        if (!rst && (ov0 || ov1)) begin
            if (q.size() == 0) begin
                total++; bad++;
                $display("FAIL R11 unexpected result: got out_valid=%0b/%0b exp 0", ov0, ov1);
            end else begin
                item_t it;
                it = q.pop_front();
                total++;
                if (!(ov0 && ov1)) begin
                    bad++;
                    $display("FAIL R11 %s: got out_valid=%0b/%0b exp 1/1", it.tag, ov0, ov1);
                end
                cmp(it.tag, "zl0", it.m0, tk0, nx0, lk0, la0, np0, ri0, cp0);
                cmp(it.tag, "zl1", it.m1, tk1, nx1, lk1, la1, np1, ri1, cp1);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        total++;
        if (ov0 || tk0 || lk0 || np0 || ri0 || cp0 || ov1 || lk1) begin
            bad++;
            $display("FAIL R11 reset: got ov=%0b tk=%0b lk=%0b np=%0b ri=%0b cp=%0b exp all 0",
                ov0, tk0, lk0, np0, ri0, cp0);
        end
        rst = 1'b0;
        @(negedge clk);

        // R2 and R1: equal / not-equal, positive and negative offsets
        send("R2 eq hit",  6'h22, 2'd0, 0, 3, 4, 32'd7, 32'd7, 0, 1, 32'h1000, 14'h0040);
        send("R2 eq miss", 6'h22, 2'd0, 0, 0, 0, 32'd7, 32'd8, 0, 1, 32'h1000, 14'h0040);
        send("R1 neg off", 6'h22, 2'd0, 0, 5, 5, 32'd1, 32'd1, 0, 1, 32'h2000, 14'h0011);
        send("R2 ne hit",  6'h2a, 2'd0, 0, 5, 5, 32'd1, 32'd2, 0, 1, 32'h3000, 14'h1ffe);
        send("R2 ne miss", 6'h2a, 2'd0, 0, 1, 2, 32'd9, 32'd9, 0, 1, 32'h3000, 14'h1ffe);
        idle();
        // R3 signed >=
        send("R3 same uncond", 6'h22, 2'd2, 0, 3, 3, 32'd1, 32'd5, 0, 1, 32'h400, 14'h0020);
        send("R3 rs0 le0",     6'h22, 2'd2, 0, 0, 5, 32'd9, 32'hffffffff, 0, 1, 32'h400, 14'h0020);
        send("R3 rs0 pos",     6'h22, 2'd2, 0, 0, 5, 32'd0, 32'd1, 0, 1, 32'h400, 14'h0020);
        send("R3 ge signed",   6'h22, 2'd2, 0, 2, 5, 32'd2, 32'hfffffffd, 0, 1, 32'h400, 14'h0020);
        send("R3 lt signed",   6'h22, 2'd2, 0, 2, 5, 32'hfffffffd, 32'd2, 0, 1, 32'h400, 14'h0020);
        // R4 signed <
        send("R4 same nop",    6'h2a, 2'd2, 0, 7, 7, 32'd0, 32'd5, 0, 1, 32'h800, 14'h0100);
        send("R4 rs0 gt0",     6'h2a, 2'd2, 0, 0, 3, 32'd0, 32'd4, 0, 1, 32'h800, 14'h0100);
        send("R4 lt signed",   6'h2a, 2'd2, 0, 1, 2, 32'hffffffff, 32'd0, 0, 1, 32'h800, 14'h0100);
        send("R4 both zero",   6'h2a, 2'd2, 0, 0, 0, 32'd0, 32'd0, 0, 1, 32'h800, 14'h0100);
        idle(); idle();
        // R5 / R7 unsigned >=
        send("R5 R7 same",     6'h22, 2'd3, 0, 6, 6, 32'hfffffffb, 32'hfffffffb, 0, 1, 32'h900, 14'h0008);
        send("R5 R7 rt0",      6'h22, 2'd3, 0, 4, 0, 32'd0, 32'd0, 0, 1, 32'h900, 14'h0008);
        send("R5 R7 rs0 neg",  6'h22, 2'd3, 0, 0, 4, 32'd0, 32'hffffffff, 0, 1, 32'h900, 14'h0008);
        send("R5 R7 rs0 zero", 6'h22, 2'd3, 0, 0, 4, 32'd0, 32'd0, 0, 1, 32'h900, 14'h0008);
        send("R5 geu big",     6'h22, 2'd3, 0, 2, 3, 32'hffffffff, 32'd1, 0, 1, 32'h900, 14'h0008);
        send("R5 geu small",   6'h22, 2'd3, 0, 2, 3, 32'd1, 32'hffffffff, 0, 1, 32'h900, 14'h0008);
        // R6 / R7 unsigned <
        send("R6 R7 rs0",      6'h2a, 2'd3, 0, 0, 3, 32'd0, 32'd4, 0, 1, 32'ha00, 14'h0009);
        send("R6 R7 same",     6'h2a, 2'd3, 0, 4, 4, 32'h80000000, 32'h80000000, 0, 1, 32'ha00, 14'h0009);
        send("R6 R7 both0",    6'h2a, 2'd3, 0, 0, 0, 32'd0, 32'd0, 0, 1, 32'ha00, 14'h0009);
        send("R6 ltu big",     6'h2a, 2'd3, 0, 1, 2, 32'd1, 32'hffffffff, 0, 1, 32'ha00, 14'h0009);
        send("R6 ltu small",   6'h2a, 2'd3, 0, 1, 2, 32'hffffffff, 32'd1, 0, 1, 32'ha00, 14'h0009);
        idle();
        // R8 floating-point subgroup
        send("R8 clr hit",   6'h22, 2'd1, 5'd8, 1, 2, 0, 0, 0, 1, 32'hb00, 14'h0004);
        send("R8 clr miss",  6'h22, 2'd1, 5'd8, 1, 2, 0, 0, 1, 1, 32'hb00, 14'h0004);
        send("R8 set hit",   6'h22, 2'd1, 5'd9, 1, 2, 0, 0, 1, 1, 32'hb00, 14'h0004);
        send("R8 set miss",  6'h22, 2'd1, 5'd9, 1, 2, 0, 0, 0, 1, 32'hb00, 14'h0004);
        send("R8 fpu off",   6'h22, 2'd1, 5'd8, 1, 2, 0, 0, 0, 0, 32'hb00, 14'h0004);
        // R9 reserved
        send("R9 fp code",   6'h22, 2'd1, 5'd3, 1, 2, 0, 0, 0, 1, 32'hc00, 14'h0004);
        send("R9 grpB hole", 6'h2a, 2'd1, 0, 1, 2, 0, 0, 0, 1, 32'hc00, 14'h0004);
        send("R9 bad major", 6'h10, 2'd0, 0, 1, 1, 5, 5, 0, 1, 32'hc00, 14'h0004);
        // R10: nop after exception leaves nothing behind
        send("R10 nop",      6'h2a, 2'd3, 0, 0, 0, 32'd3, 32'd3, 0, 1, 32'hd00, 14'h0004);
        idle(); idle(); idle();
        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout exp completion");
        end
        if (q.size() != 0) begin
            total++; bad++;
            $display("FAIL R11 missing results: got %0d pending exp 0", q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule